// File: doc/BRIEF.md
# Event-Triggered Time Interval Counter

This block measures the time between a start event and a stop event in units of measurement-clock edges. A 2-bit command starts a measurement, clears the previous outcome, or aborts a measurement in progress. A control state machine then arms on the start condition and counts while the interval is open. It closes the interval on a stop condition, or on saturation at a chosen result bit. The block is modelled on a single clock, so each rising edge stands for two counted edges: one rising and one falling.

Each event input has its own polarity bit. There are two ways to start. The edge-armed start first requires the start event to be seen inactive, so counting always begins on a real transition. The level start begins counting as soon as the start event is active. A skip counter can discard a set number of stop transitions before the one that ends the measurement. This gives multi-period or Nth-event measurements. The current state is always visible on a 6-bit code output.

Top module: `tdc_engine`

## Requirements
- R1: While reset is asserted, the state code is 0x0F, the result is 2 and both flags are 0. On the first clock edge after reset is released, the state code becomes 0x06 (idle).
- R2: Command encoding on `cmd` with `cmd_valid` high is: 0 = clear, 1 = edge-armed start, 2 = level start, 3 = abort. A start command issued outside idle has no effect on the running measurement.
- R3: Level start (cmd 2): the first clock edge that sees the start event active is the recognition edge. The final result is 2 × (number of edges from start recognition to stop recognition).
- R4: Edge-armed start (cmd 1): if the start event is already active, the block waits in state 0x1E until the event is seen inactive. It then waits in state 0x00 and counts only from the next active level.
- R5: An event is active when `evt XOR pol` is 1, so polarity 0 means active-high and polarity 1 means active-low.
- R6: A stop is recognised only on a transition of the stop event from inactive to active. Each counting edge, including the one that recognises the stop, adds 2 to the result.
- R7: `sat_sel` values 3..15 select result bit 12..24, and values below 3 act as 3. When the selected bit is set on a counting edge, the measurement ends with a result of 2^bit + 2 and the saturation flag set. This also applies if a stop is recognised on the same edge.
- R8: With `skip_en` high, `skip_load` is copied into the skip counter at measurement start. That many stop transitions are ignored (each one decrements `skip_left`) before a stop transition ends the measurement.
- R9: A `skip_wr` pulse replaces the remaining skip count with `skip_wdata` only while skipping with a nonzero remaining count. Otherwise it leaves `skip_left` unchanged.
- R10: When a measurement ends, `done_pulse` is high for exactly one cycle, in state 0x0E, and `done_flag` is set. A new start clears both flags.
- R11: A clear command in idle sets the result and both flags to 0 on the next edge. A clear command outside idle is ignored.
- R12: An abort goes through state 0x2E to idle without setting `done_flag`. An abort that arrives during state 0x07 is held: the block passes through 0x16 and then 0x2E to idle.
- R13: The state codes are: idle 0x06, reset 0x0F, await start 0x00, clear 0x07, clear wait 0x16, await stop 0x08, skipping 0x0C, latch 0x0E, await start inactive 0x1E, and abort 0x2E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 2 | Command code (0 clear, 1 edge start, 2 level start, 3 abort) |
| start_evt | input | 1 | Start event level |
| start_pol | input | 1 | Start polarity (1 = active-low) |
| stop_evt | input | 1 | Stop event level |
| stop_pol | input | 1 | Stop polarity (1 = active-low) |
| sat_sel | input | 4 | Saturation bit select |
| skip_en | input | 1 | Enable skip counter load at start |
| skip_load | input | 8 | Number of stop transitions to ignore |
| skip_wr | input | 1 | Overwrite remaining skip count |
| skip_wdata | input | 8 | New remaining skip count |
| result | output | 25 | Measured interval in clock edges |
| done_flag | output | 1 | Measurement completed |
| sat_flag | output | 1 | Measurement ended by saturation |
| done_pulse | output | 1 | One-cycle completion strobe |
| skip_left | output | 8 | Remaining stop transitions to ignore |
| state_code | output | 6 | Current control state code |

## Verification
A stop recognition and a saturation hit can fall on the same counting edge. The bench sets the limit to bit 12 and places the stop transition exactly 2049 edges after start recognition. This is the edge on which the 4096 result is first seen with bit 12 set, and the bench expects a result of 4098 with the saturation flag raised. The same setup with the stop one edge earlier must end with 4096 and the flag clear. This confirms that saturation is judged on the registered count and not on the incremented one.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic [5:0] {
    ST_ARMED    = 6'h00,
    ST_IDLE     = 6'h06,
    ST_CLEAR    = 6'h07,
    ST_MEASURE  = 6'h08,
    ST_SKIP     = 6'h0C,
    ST_LATCH    = 6'h0E,
    ST_POR      = 6'h0F,
    ST_CLR_WAIT = 6'h16,
    ST_QUIET    = 6'h1E,
    ST_ABORT    = 6'h2E
  } tdc_state_e;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_SYNC  = 2'd1,
    OP_ASYNC = 2'd2,
    OP_ABORT = 2'd3
  } tdc_op_e;

  localparam int unsigned SAT_SEL_MIN = 3;
  localparam int unsigned SAT_BIT_OFS = 9;

  // Map the 4-bit saturation select onto a result bit index.
  function automatic int unsigned sat_bit_index(input logic [3:0] sel);
    int unsigned s;
    s = int'(sel);
    if (s < SAT_SEL_MIN) s = SAT_SEL_MIN;
    return s + SAT_BIT_OFS;
  endfunction

  function automatic logic is_counting(input tdc_state_e st);
    return (st == ST_MEASURE) || (st == ST_SKIP);
  endfunction

endpackage

// File: rtl/tdc_stop_edge.sv
module tdc_stop_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic pol,
  output logic hit
);
  logic active;
  logic prev_q;

  assign active = evt ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= active;
  end

  assign hit = active & ~prev_q;

  // R6
  stop_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/tdc_span_counter.sv
module tdc_span_counter #(
  parameter int unsigned RES_W     = 25,
  parameter int unsigned RESET_VAL = 2,
  parameter int unsigned STEP      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             count_en,
  input  logic [3:0]       sat_sel,
  output logic [RES_W-1:0] result,
  output logic             sat_hit
);
  import tdc_pkg::*;

  localparam int unsigned IDX_W = $clog2(RES_W);

  function automatic logic [RES_W-1:0] advance(input logic [RES_W-1:0] v);
    return v + RES_W'(STEP);
  endfunction

  logic [IDX_W-1:0] sat_idx;
  logic [RES_W-1:0] cnt_q;

  assign sat_idx = IDX_W'(sat_bit_index(sat_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= RES_W'(RESET_VAL);
    else if (clr)      cnt_q <= '0;
    else if (count_en) cnt_q <= advance(cnt_q);
  end

  assign result  = cnt_q;
  assign sat_hit = count_en & cnt_q[sat_idx];

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(result));
  // R6
  step_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clr) |=> (result == $past(result) + RES_W'(STEP)));
endmodule

// File: rtl/tdc_skip_counter.sv
module tdc_skip_counter #(
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SKIP_W-1:0] load_val,
  input  logic              wr_en,
  input  logic [SKIP_W-1:0] wr_val,
  input  logic              dec,
  output logic [SKIP_W-1:0] cnt,
  output logic              zero
);
  logic [SKIP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (wr_en) cnt_q <= wr_val;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R9
  empty_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
  // R8
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !wr_en) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic       start_act,
  input  logic       stop_hit,
  input  logic       sat_hit,
  input  logic       skip_zero,
  output tdc_state_e state,
  output logic       count_en,
  output logic       clr_result,
  output logic       load_skip,
  output logic       dec_skip,
  output logic       skip_wr_ok,
  output logic       done_flag,
  output logic       sat_flag,
  output logic       done_pulse
);
  tdc_state_e state_q, state_d;
  logic sync_q, abort_pend_q;
  logic op_clear, op_sync, op_async, op_abort;
  logic start_req, enter_latch, end_hit;

  assign op_clear  = cmd_valid && (tdc_op_e'(cmd) == OP_CLEAR);
  assign op_sync   = cmd_valid && (tdc_op_e'(cmd) == OP_SYNC);
  assign op_async  = cmd_valid && (tdc_op_e'(cmd) == OP_ASYNC);
  assign op_abort  = cmd_valid && (tdc_op_e'(cmd) == OP_ABORT);
  assign start_req = (state_q == ST_IDLE) && (op_sync || op_async);
  assign end_hit   = sat_hit || stop_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:      state_d = ST_IDLE;
      ST_IDLE: begin
        if (op_sync || op_async) state_d = ST_CLEAR;
        else if (op_abort)       state_d = ST_ABORT;
      end
      ST_CLEAR:    state_d = ST_CLR_WAIT;
      ST_CLR_WAIT: begin
        if (abort_pend_q || op_abort) state_d = ST_ABORT;
        else if (sync_q)              state_d = ST_QUIET;
        else                          state_d = ST_ARMED;
      end
      ST_QUIET: begin
        if (op_abort)        state_d = ST_ABORT;
        else if (!start_act) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (op_abort)       state_d = ST_ABORT;
        else if (start_act) state_d = skip_zero ? ST_MEASURE : ST_SKIP;
      end
      ST_SKIP: begin
        if (op_abort)                    state_d = ST_ABORT;
        else if (sat_hit)                state_d = ST_LATCH;
        else if (stop_hit && skip_zero)  state_d = ST_LATCH;
        else if (!stop_hit && skip_zero) state_d = ST_MEASURE;
      end
      ST_MEASURE: begin
        if (op_abort)     state_d = ST_ABORT;
        else if (end_hit) state_d = ST_LATCH;
      end
      ST_LATCH:    state_d = ST_IDLE;
      ST_ABORT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign enter_latch = (state_d == ST_LATCH) && (state_q != ST_LATCH);
  assign count_en    = is_counting(state_q);
  assign clr_result  = (state_q == ST_CLEAR) || ((state_q == ST_IDLE) && op_clear);
  assign load_skip   = (state_q == ST_CLEAR);
  assign dec_skip    = (state_q == ST_SKIP) && stop_hit && !skip_zero && !op_abort && !sat_hit;
  assign skip_wr_ok  = (state_q == ST_SKIP) && !skip_zero;
  assign done_pulse  = (state_q == ST_LATCH);
  assign state       = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_POR;
      sync_q       <= 1'b0;
      abort_pend_q <= 1'b0;
      done_flag    <= 1'b0;
      sat_flag     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_req) sync_q <= op_sync;
      if (state_q == ST_CLEAR) abort_pend_q <= op_abort;
      else                     abort_pend_q <= 1'b0;
      if (clr_result) begin
        done_flag <= 1'b0;
        sat_flag  <= 1'b0;
      end else if (enter_latch) begin
        done_flag <= 1'b1;
        sat_flag  <= sat_hit;
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  // R10
  sat_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> done_flag);
  // R12
  clear_holds_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR) |=> (state_q == ST_CLR_WAIT));
  // R12
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT) |=> (state_q == ST_IDLE && !done_pulse));
  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_CLEAR));
endmodule

// File: rtl/tdc_engine.sv
module tdc_engine #(
  parameter int unsigned RES_W  = 25,
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  input  logic              start_evt,
  input  logic              start_pol,
  input  logic              stop_evt,
  input  logic              stop_pol,
  input  logic [3:0]        sat_sel,
  input  logic              skip_en,
  input  logic [SKIP_W-1:0] skip_load,
  input  logic              skip_wr,
  input  logic [SKIP_W-1:0] skip_wdata,
  output logic [RES_W-1:0]  result,
  output logic              done_flag,
  output logic              sat_flag,
  output logic              done_pulse,
  output logic [SKIP_W-1:0] skip_left,
  output logic [5:0]        state_code
);
  import tdc_pkg::*;

  localparam int unsigned RESET_RESULT = 2;
  localparam int unsigned EDGE_STEP    = 2;

  tdc_state_e        state;
  logic              start_act, stop_hit, sat_hit, skip_zero;
  logic              count_en, clr_result, load_skip, dec_skip, skip_wr_ok;
  logic [SKIP_W-1:0] skip_init;

  assign start_act = start_evt ^ start_pol;
  assign skip_init = skip_en ? skip_load : '0;

  tdc_stop_edge u_stop (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (stop_evt),
    .pol   (stop_pol),
    .hit   (stop_hit)
  );

  tdc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .start_act  (start_act),
    .stop_hit   (stop_hit),
    .sat_hit    (sat_hit),
    .skip_zero  (skip_zero),
    .state      (state),
    .count_en   (count_en),
    .clr_result (clr_result),
    .load_skip  (load_skip),
    .dec_skip   (dec_skip),
    .skip_wr_ok (skip_wr_ok),
    .done_flag  (done_flag),
    .sat_flag   (sat_flag),
    .done_pulse (done_pulse)
  );

  tdc_span_counter #(
    .RES_W     (RES_W),
    .RESET_VAL (RESET_RESULT),
    .STEP      (EDGE_STEP)
  ) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_result),
    .count_en (count_en),
    .sat_sel  (sat_sel),
    .result   (result),
    .sat_hit  (sat_hit)
  );

  tdc_skip_counter #(
    .SKIP_W (SKIP_W)
  ) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_skip),
    .load_val (skip_init),
    .wr_en    (skip_wr && skip_wr_ok),
    .wr_val   (skip_wdata),
    .dec      (dec_skip),
    .cnt      (skip_left),
    .zero     (skip_zero)
  );

  assign state_code = state;
endmodule

// File: tb/sim_tdc_engine.sv
module sim_tdc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic        start_evt = 1'b0, start_pol = 1'b0;
  logic        stop_evt = 1'b0, stop_pol = 1'b0;
  logic [3:0]  sat_sel = 4'hF;
  logic        skip_en = 1'b0;
  logic [7:0]  skip_load = 8'd0;
  logic        skip_wr = 1'b0;
  logic [7:0]  skip_wdata = 8'd0;
  logic [24:0] result;
  logic        done_flag, sat_flag, done_pulse;
  logic [7:0]  skip_left;
  logic [5:0]  state_code;

  always #4 clk = ~clk;

  tdc_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .start_evt(start_evt), .start_pol(start_pol),
    .stop_evt(stop_evt), .stop_pol(stop_pol), .sat_sel(sat_sel),
    .skip_en(skip_en), .skip_load(skip_load), .skip_wr(skip_wr),
    .skip_wdata(skip_wdata), .result(result), .done_flag(done_flag),
    .sat_flag(sat_flag), .done_pulse(done_pulse), .skip_left(skip_left),
    .state_code(state_code)
  );

  typedef struct { longint res; bit sat; string req; } exp_t;
  exp_t sb[$];
  int  n_chk = 0, n_bad = 0, t_rel = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    t_rel += n;
  endtask

  task automatic set_start(input bit act); start_evt = act ^ start_pol; endtask
  task automatic set_stop(input bit act);  stop_evt  = act ^ stop_pol;  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic push(input longint res, input bit sat, input string req);
    exp_t e; e.res = res; e.sat = sat; e.req = req;
    sb.push_back(e);
  endtask

  function automatic longint sat_result(input int sel);
    int b; b = (sel < 3) ? 12 : sel + 9;
    return (longint'(1) << b) + 2;
  endfunction

  // Arm, open the interval, then close by stop after d edges or wait d edges.
  task automatic measure(input logic [1:0] op, input int d, input bit use_stop,
                         input longint exp_res, input bit exp_sat, input string req);
    set_start(0); set_stop(0);
    issue(op);
    repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    push(exp_res, exp_sat, req);
    tick(d);
    if (use_stop) begin
      set_stop(1); tick(1); set_stop(0);
    end
    set_start(0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_stop(input int gap);
    tick(gap); set_stop(1); tick(1); set_stop(0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_pulse) begin
      if (sb.size() == 0) begin
        chk(0, "R10", "unexpected done_pulse", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, e.req, "result", result, e.res);
        chk(sat_flag == e.sat, e.req, "sat_flag", sat_flag, e.sat);
        chk(done_flag == 1'b1, "R10", "done_flag at pulse", done_flag, 1);
        chk(state_code == 6'h0E, "R13", "latch code", state_code, 6'h0E);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(state_code == 6'h0F, "R1", "state in reset", state_code, 6'h0F);
    chk(result == 25'd2, "R1", "result in reset", result, 2);
    chk(!done_flag && !sat_flag, "R1", "flags in reset", {done_flag, sat_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state_code == 6'h06, "R1", "idle after reset", state_code, 6'h06);
    repeat (2) @(negedge clk);

    // R3 level start, plain interval
    measure(2'd2, 9, 1, 18, 0, "R3");
    // R4 edge-armed start, plain interval
    measure(2'd1, 5, 1, 10, 0, "R4");

    // R4 edge-armed start with event already active
    set_start(1); set_stop(0);
    issue(2'd1);
    repeat (8) @(negedge clk);
    chk(state_code == 6'h1E, "R4", "waiting for inactive", state_code, 6'h1E);
    set_start(0);
    repeat (3) @(negedge clk);
    chk(state_code == 6'h00, "R13", "armed code", state_code, 6'h00);
    set_start(1); t_rel = 0;
    tick(6); push(2 * t_rel, 0, "R4");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R3 level start with event already active: recognised on third edge
    set_start(1);
    issue(2'd2);
    repeat (2) @(negedge clk); t_rel = 0;
    tick(5); push(2 * t_rel, 0, "R3");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R5 active-low polarity on both events
    start_pol = 1'b1; stop_pol = 1'b1;
    measure(2'd2, 7, 1, 14, 0, "R5");
    chk(stop_evt == 1'b1, "R5", "idle stop level", stop_evt, 1);
    start_pol = 1'b0; stop_pol = 1'b0;
    set_start(0); set_stop(0);

    // R6 stop held active before start is not a transition
    set_stop(1);
    issue(2'd2);
    repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    tick(4);
    chk(state_code == 6'h08, "R6", "held stop ignored", state_code, 6'h08);
    set_stop(0); tick(2);
    push(2 * t_rel, 0, "R6");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R7 saturation and coincidence with stop
    sat_sel = 4'd3;
    measure(2'd2, 2048, 1, 4096, 0, "R7");
    measure(2'd2, 2049, 1, sat_result(3), 1, "R7");
    sat_sel = 4'd0;
    measure(2'd2, 2100, 0, sat_result(0), 1, "R7");
    sat_sel = 4'd4;
    measure(2'd2, 4200, 0, sat_result(4), 1, "R7");

    // R11 clear in idle
    chk(done_flag && sat_flag, "R11", "flags before clear", {done_flag, sat_flag}, 3);
    issue(2'd0);
    chk(result == 0, "R11", "result cleared", result, 0);
    chk(!done_flag && !sat_flag, "R11", "flags cleared", {done_flag, sat_flag}, 0);
    sat_sel = 4'hF;

    // R10 new start clears flags
    measure(2'd2, 3, 1, 6, 0, "R10");
    issue(2'd2);
    @(negedge clk);
    chk(!done_flag, "R10", "start clears done", done_flag, 0);
    issue(2'd3);
    repeat (3) @(negedge clk);

    // R11 clear outside idle ignored
    set_start(0); set_stop(0);
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    tick(2); cmd_valid = 1'b1; cmd = 2'd0; tick(1); cmd_valid = 1'b0;
    tick(3); push(2 * t_rel, 0, "R11");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R2 start command while measuring ignored
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    tick(2); cmd_valid = 1'b1; cmd = 2'd1; tick(1); cmd_valid = 1'b0;
    tick(4); push(2 * t_rel, 0, "R2");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R8 skip two stop transitions
    skip_en = 1'b1; skip_load = 8'd2;
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    @(negedge clk); t_rel++;
    chk(skip_left == 2, "R8", "loaded count", skip_left, 2);
    chk(state_code == 6'h0C, "R13", "skipping code", state_code, 6'h0C);
    pulse_stop(3);
    chk(skip_left == 1, "R8", "after first skip", skip_left, 1);
    pulse_stop(3);
    chk(skip_left == 0, "R8", "after second skip", skip_left, 0);
    tick(3); push(2 * t_rel, 0, "R8");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R9 overwrite while skipping
    skip_load = 8'd1;
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    tick(2); skip_wr = 1'b1; skip_wdata = 8'd3; tick(1); skip_wr = 1'b0;
    chk(skip_left == 3, "R9", "overwrite taken", skip_left, 3);
    pulse_stop(3); pulse_stop(3); pulse_stop(3);
    chk(skip_left == 0, "R9", "count drained", skip_left, 0);
    tick(3); push(2 * t_rel, 0, "R9");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R9 overwrite with nothing left is ignored
    skip_en = 1'b0;
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1); t_rel = 0;
    tick(2); skip_wr = 1'b1; skip_wdata = 8'd5; tick(1); skip_wr = 1'b0;
    chk(skip_left == 0, "R9", "overwrite ignored", skip_left, 0);
    tick(3); push(2 * t_rel, 0, "R9");
    set_stop(1); tick(1); set_stop(0); set_start(0);
    repeat (4) @(negedge clk);

    // R12 abort while measuring
    issue(2'd2); repeat (5) @(negedge clk);
    set_start(1);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'd3; @(negedge clk); cmd_valid = 1'b0;
    chk(state_code == 6'h2E, "R12", "abort state", state_code, 6'h2E);
    @(negedge clk);
    chk(state_code == 6'h06, "R12", "idle after abort", state_code, 6'h06);
    chk(!done_flag, "R12", "no done on abort", done_flag, 0);
    set_start(0);
    repeat (2) @(negedge clk);

    // R12 abort during clear is held
    @(negedge clk); cmd_valid = 1'b1; cmd = 2'd2;
    @(negedge clk); cmd = 2'd3;
    @(negedge clk); cmd_valid = 1'b0;
    chk(state_code == 6'h16, "R12", "clear wait despite abort", state_code, 6'h16);
    @(negedge clk);
    chk(state_code == 6'h2E, "R12", "deferred abort", state_code, 6'h2E);
    @(negedge clk);
    chk(state_code == 6'h06, "R12", "idle after deferred", state_code, 6'h06);
    chk(result == 0, "R12", "result after deferred", result, 0);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R10", "outstanding results", sb.size(), 0);
    report();
  end
endmodule